// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device end of a three-wire serial EEPROM. A host raises chip select, clocks a start bit, a two-bit opcode and an address field into the serial input, and gets read data or programming status back on the serial output. The internal storage is one array. A width-select input presents it either as 16-bit words or as bytes. The block carries out single and streaming reads, word or byte writes, single-location and whole-array erase, whole-array fill, and the program-enable and program-lock commands. Programming is self-timed: a counter runs in system clock cycles, and the host may poll ready or busy on the serial output.

The serial pins are sampled by the system clock through a synchronizer with edge detection. A state machine does all sequencing. Its states are IDLE, START, OPC, ADDR, DATA, READ, BUSY, READY and SKIP:
- IDLE goes to START on a chip-select rise.
- START goes to OPC on a one bit.
- OPC goes to ADDR after two bits.
- ADDR goes to one of four states. A read goes to READ. A write or fill goes to DATA while programming is unlocked. An erase goes to BUSY while programming is unlocked. Every other case goes to SKIP.
- DATA goes to BUSY after the last data bit.
- BUSY goes to READY, SKIP or IDLE when the timer expires.
- Every non-BUSY state returns to IDLE when chip select falls.

The output enable is a separate port, and the pad tri-states the pin with it.

Top module: `mw_eeprom_dev`

## Requirements
- R1: A command begins only after chip select rises. Zeros before the first one on the serial input are ignored, and that first one is the start bit. Two opcode bits follow it, then the address, MSB first. The address is 8 bits in word mode and 9 bits in byte mode.
- R2: The opcodes are 10 read, 01 write and 11 erase. Opcode 00 takes its sub-command from the two top address bits: 11 unlock programming, 10 erase all, 01 fill all, 00 lock programming. The remaining address bits are ignored but must still be clocked.
- R3: After a read address, the output drives a single 0. It does so at the shift-clock rise that samples the last address bit. On each later rise it presents the data MSB first, one bit per rise.
- R4: While chip select stays high, a read moves on to the next address with no extra 0 between words. It wraps from the top address back to address 0.
- R5: With org_wide_i high, data is 16 bits wide. With it low, data is 8 bits wide, and byte address b selects word b/2: the low half when b is even, the high half when b is odd.
- R6: After reset, programming is locked. Write, erase, erase-all and fill-all then leave the array unchanged. Reads work whether programming is locked or unlocked.
- R7: Erase sets every bit of the addressed location to 1, and erase-all does so for every location. Write stores its data into one location and fill-all into every location, with no prior erase needed.
- R8: Programming keeps the block busy for PROG_CYCLES system clocks. For a write or fill it starts after the last data bit. For an erase it starts after the last address bit.
- R9: If chip select is lowered and then raised during programming, the output drives 0 while busy. It drives 1 once ready, until chip select falls. If chip select is raised only after programming has ended, nothing is driven.
- R10: When chip select is low, the output is released: sdo_oe_o goes low within the synchronizer latency.
- R11: A command sent while programming is in progress is ignored.
- R12: If chip select falls before a command is complete, the partial command is discarded and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_wide_i | input | 1 | 1: 16-bit words, 0: bytes |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output (read data or ready/busy) |
| sdo_oe_o | output | 1 | Output enable for sdo_o, 0 means high impedance |

## Verification
A wrong bit counter or a wrong address shift shows on the very next read. The dummy 0 lands one shift-clock rise early or late, or the data stream comes out of the wrong location. Either way, every following bit of the stream compares wrong. A wrong lock flag or a wrong timer state shows at the next poll: as a missing or premature ready, or as a write that left the array changed or unchanged when it should not have. Streaming reads across the top address and across byte halves expose pointer masking faults within two words.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_BUSY,
        ST_READY,
        ST_SKIP
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_WIPE   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign q    = pipe[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int AW_BYTE = 9
) (
    input  logic               clk,
    input  logic               wide,
    input  logic               wr_one,
    input  logic               wr_all,
    input  logic [AW_BYTE-1:0] wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [AW_BYTE-1:0] rd_addr,
    output logic [15:0]        rd_bits
);
    localparam int WA    = AW_BYTE - 1;
    localparam int WORDS = 2 ** WA;

    logic [15:0]   mem [WORDS];
    logic [WA-1:0] rd_sel;
    logic [15:0]   rd_word;

    always_ff @(posedge clk) begin
        if (wr_all) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= wide ? wr_data : {wr_data[7:0], wr_data[7:0]};
        end else if (wr_one) begin
            if (wide)
                mem[wr_addr[WA-1:0]] <= wr_data;
            else if (wr_addr[0])
                mem[wr_addr[WA:1]][15:8] <= wr_data[7:0];
            else
                mem[wr_addr[WA:1]][7:0] <= wr_data[7:0];
        end
    end

    assign rd_sel  = wide ? rd_addr[WA-1:0] : rd_addr[WA:1];
    assign rd_word = mem[rd_sel];
    assign rd_bits = wide ? rd_word
                          : {8'h00, (rd_addr[0] ? rd_word[15:8] : rd_word[7:0])};
endmodule

// File: rtl/mw_eeprom_dev.sv
module mw_eeprom_dev #(
    parameter int AW_BYTE     = 9,
    parameter int PROG_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide_i,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    import mw_pkg::*;

    localparam int AWW = AW_BYTE - 1;
    localparam int CNW = 5;

    logic [2:0] pin_q, pin_rise, pin_fall;
    logic cs_q, sck_rise, di_q, cs_rise;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({sdi_i, sck_i, cs_i}),
        .q(pin_q), .rise(pin_rise), .fall(pin_fall)
    );

    assign cs_q     = pin_q[0];
    assign cs_rise  = pin_rise[0];
    assign sck_rise = pin_rise[1];
    assign di_q     = pin_q[2];

    mw_state_e          state_q, state_d;
    logic [CNW-1:0]     bitcnt_q, bitcnt_d;
    logic [1:0]         op_q, op_d;
    logic [AW_BYTE-1:0] addr_q, addr_d, rd_ptr_q, rd_ptr_d;
    logic [15:0]        data_q, data_d;
    logic               sdo_q, sdo_d, wr_en_q, wr_en_d, poll_q, poll_d;

    logic               prog_start, st_one, st_all, busy;
    logic [AW_BYTE-1:0] st_addr;
    logic [15:0]        st_data, rd_bits, data_nx;
    logic [AW_BYTE-1:0] addr_nx, ptr_mask;
    logic [CNW-1:0]     addr_len, data_len;
    logic [1:0]         sub;
    logic               rd_bit;

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    mw_store #(.AW_BYTE(AW_BYTE)) store_i (
        .clk(clk), .wide(org_wide_i), .wr_one(st_one), .wr_all(st_all),
        .wr_addr(st_addr), .wr_data(st_data), .rd_addr(rd_ptr_q), .rd_bits(rd_bits)
    );

    assign addr_len = org_wide_i ? CNW'(AWW) : CNW'(AW_BYTE);
    assign data_len = org_wide_i ? CNW'(16) : CNW'(8);
    assign addr_nx  = {addr_q[AW_BYTE-2:0], di_q};
    assign data_nx  = {data_q[14:0], di_q};
    assign sub      = org_wide_i ? addr_nx[AWW-1 -: 2] : addr_nx[AW_BYTE-1 -: 2];
    assign ptr_mask = org_wide_i ? {1'b0, {AWW{1'b1}}} : {AW_BYTE{1'b1}};
    assign rd_bit   = org_wide_i ? rd_bits[4'(5'd15 - bitcnt_q)]
                                 : rd_bits[4'(5'd7 - bitcnt_q)];

    // next-state and datapath
    always_comb begin
        state_d    = state_q;
        bitcnt_d   = bitcnt_q;
        op_d       = op_q;
        addr_d     = addr_q;
        rd_ptr_d   = rd_ptr_q;
        data_d     = data_q;
        sdo_d      = sdo_q;
        wr_en_d    = wr_en_q;
        poll_d     = poll_q;
        prog_start = 1'b0;
        st_one     = 1'b0;
        st_all     = 1'b0;
        st_addr    = addr_q;
        st_data    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_rise) state_d = ST_START;
            end
            ST_START: begin
                if (!cs_q) state_d = ST_IDLE;
                else if (sck_rise && di_q) begin
                    state_d  = ST_OPC;
                    bitcnt_d = '0;
                    op_d     = '0;
                end
            end
            ST_OPC: begin
                if (!cs_q) state_d = ST_IDLE;
                else if (sck_rise) begin
                    op_d = {op_q[0], di_q};
                    if (bitcnt_q == CNW'(1)) begin
                        state_d  = ST_ADDR;
                        bitcnt_d = '0;
                        addr_d   = '0;
                    end else bitcnt_d = bitcnt_q + 1'b1;
                end
            end
            ST_ADDR: begin
                if (!cs_q) state_d = ST_IDLE;
                else if (sck_rise) begin
                    addr_d   = addr_nx;
                    bitcnt_d = bitcnt_q + 1'b1;
                    if (bitcnt_q == addr_len - 1'b1) begin
                        bitcnt_d = '0;
                        state_d  = ST_SKIP;
                        data_d   = '0;
                        unique case (op_q)
                            OP_READ: begin
                                state_d  = ST_READ;
                                rd_ptr_d = addr_nx & ptr_mask;
                                sdo_d    = 1'b0;
                            end
                            OP_WRITE: begin
                                if (wr_en_q) state_d = ST_DATA;
                            end
                            OP_ERASE: begin
                                if (wr_en_q) begin
                                    st_one     = 1'b1;
                                    st_addr    = addr_nx;
                                    st_data    = '1;
                                    prog_start = 1'b1;
                                    poll_d     = 1'b0;
                                    state_d    = ST_BUSY;
                                end
                            end
                            default: begin
                                unique case (sub)
                                    SUB_UNLOCK: wr_en_d = 1'b1;
                                    SUB_LOCK:   wr_en_d = 1'b0;
                                    SUB_FILL: begin
                                        if (wr_en_q) state_d = ST_DATA;
                                    end
                                    default: begin
                                        if (wr_en_q) begin
                                            st_all     = 1'b1;
                                            st_data    = '1;
                                            prog_start = 1'b1;
                                            poll_d     = 1'b0;
                                            state_d    = ST_BUSY;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
            end
            ST_DATA: begin
                if (!cs_q) state_d = ST_IDLE;
                else if (sck_rise) begin
                    data_d   = data_nx;
                    bitcnt_d = bitcnt_q + 1'b1;
                    if (bitcnt_q == data_len - 1'b1) begin
                        bitcnt_d   = '0;
                        st_all     = (op_q == OP_EXT);
                        st_one     = (op_q != OP_EXT);
                        st_data    = data_nx;
                        prog_start = 1'b1;
                        poll_d     = 1'b0;
                        state_d    = ST_BUSY;
                    end
                end
            end
            ST_READ: begin
                if (!cs_q) state_d = ST_IDLE;
                else if (sck_rise) begin
                    sdo_d = rd_bit;
                    if (bitcnt_q == data_len - 1'b1) begin
                        bitcnt_d = '0;
                        rd_ptr_d = (rd_ptr_q + 1'b1) & ptr_mask;
                    end else bitcnt_d = bitcnt_q + 1'b1;
                end
            end
            ST_BUSY: begin
                if (!cs_q) poll_d = 1'b1;
                if (!busy) begin
                    if (!cs_q)       state_d = ST_IDLE;
                    else if (poll_q) state_d = ST_READY;
                    else             state_d = ST_SKIP;
                end
            end
            ST_READY, ST_SKIP: begin
                if (!cs_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            rd_ptr_q <= '0;
            data_q   <= '0;
            sdo_q    <= 1'b0;
            wr_en_q  <= 1'b0;
            poll_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            op_q     <= op_d;
            addr_q   <= addr_d;
            rd_ptr_q <= rd_ptr_d;
            data_q   <= data_d;
            sdo_q    <= sdo_d;
            wr_en_q  <= wr_en_d;
            poll_q   <= poll_d;
        end
    end

    // outputs
    always_comb begin
        sdo_o    = 1'b0;
        sdo_oe_o = 1'b0;
        unique case (state_q)
            ST_READ: begin
                sdo_o    = sdo_q;
                sdo_oe_o = 1'b1;
            end
            ST_BUSY: begin
                sdo_o    = 1'b0;
                sdo_oe_o = cs_q && poll_q;
            end
            ST_READY: begin
                sdo_o    = 1'b1;
                sdo_oe_o = 1'b1;
            end
            default: begin
                sdo_o    = 1'b0;
                sdo_oe_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_q,
    input logic busy,
    input logic prog_start,
    input logic wr_en,
    input logic sdo_o,
    input logic sdo_oe_o
);
    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |=> !sdo_oe_o);

    // R6
    locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !prog_start);

    // R8
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_start);

    // R9
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sdo_oe_o) |-> !sdo_o);
endmodule

bind mw_eeprom_dev mw_eeprom_chk chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .cs_q(cs_q),
    .busy(busy),
    .prog_start(prog_start),
    .wr_en(wr_en_q),
    .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o)
);

// File: tb/mw_eeprom_dev_tb.sv
module mw_eeprom_dev_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int PROG       = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org = 1'b1;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic sdo, sdo_oe;

    int total = 0;
    int bad = 0;
    logic  exp_q [$];
    string tag_q [$];
    logic [15:0] mdl [256];
    logic en_m = 1'b0;
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_dev #(.AW_BYTE(9), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .org_wide_i(org), .cs_i(cs), .sck_i(sck),
        .sdi_i(di), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(mon_ev) begin
        if (exp_q.size() > 0) begin
            logic e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(sdo_oe && (sdo == e), t, {sdo_oe, sdo}, {1'b1, e});
        end
    end

    task automatic clk_bit(input logic b);
        di = b;
        tick(HALF);
        sck = 1'b1;
        tick(6);
        -> mon_ev;
        tick(HALF - 6);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic cs_up;
        tick(4);
        cs = 1'b1;
        tick(8);
    endtask

    task automatic cs_down;
        sck = 1'b0;
        tick(2);
        cs = 1'b0;
        tick(8);
    endtask

    function automatic int aw();
        return org ? 8 : 9;
    endfunction

    function automatic int dw();
        return org ? 16 : 8;
    endfunction

    function automatic logic [15:0] get(input int a);
        logic [15:0] w;
        if (org) return mdl[a % 256];
        w = mdl[(a % 512) / 2];
        return (a % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic void put(input int a, input logic [15:0] d);
        if (org) mdl[a % 256] = d;
        else if (a % 2 == 1) mdl[(a % 512) / 2][15:8] = d[7:0];
        else mdl[(a % 512) / 2][7:0] = d[7:0];
    endfunction

    // R1, R3, R4: read n locations starting at a, expectations into the scoreboard
    task automatic do_read(input int a, input int n, input string tag);
        logic [31:0] av;
        logic [15:0] v;
        av = a;
        cs_up;
        clk_bit(1'b0);
        clk_bit(1'b1);
        send_bits(32'b10, 2);
        send_bits(av >> 1, aw() - 1);
        exp_q.push_back(1'b0);
        tag_q.push_back({tag, " R3 dummy"});
        for (int k = 0; k < n; k++) begin
            v = get(a + k);
            for (int i = dw() - 1; i >= 0; i--) begin
                exp_q.push_back(v[i]);
                tag_q.push_back(tag);
            end
        end
        clk_bit(av[0]);
        for (int i = 0; i < n * dw(); i++) clk_bit(1'b0);
        cs_down;
    endtask

    task automatic ext_cmd(input logic [1:0] s);
        logic [31:0] av;
        av = 32'(s) << (aw() - 2);
        cs_up;
        clk_bit(1'b1);
        send_bits(32'b00, 2);
        send_bits(av, aw());
        cs_down;
        if (s == 2'b11) en_m = 1'b1;
        if (s == 2'b00) en_m = 1'b0;
    endtask

    task automatic write_cmd(input int a, input logic [15:0] d);
        cs_up;
        clk_bit(1'b1);
        send_bits(32'b01, 2);
        send_bits(32'(a), aw());
        send_bits(32'(d), dw());
        cs_down;
        if (en_m) put(a, d);
    endtask

    initial begin : main
        for (int i = 0; i < 256; i++) mdl[i] = 16'hffff;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R10 reset state
        check(sdo_oe == 1'b0, "R10 reset oe", sdo_oe, 0);

        // R2 R7: unlock, erase all
        ext_cmd(2'b11);
        ext_cmd(2'b10);
        tick(PROG + 20);

        // R6: locked write has no effect, read still works
        ext_cmd(2'b00);
        write_cmd(5, 16'ha5c3);
        tick(PROG + 20);
        do_read(5, 1, "R6 locked write");

        // R9 status poll, R8 busy window
        ext_cmd(2'b11);
        write_cmd(5, 16'ha5c3);
        cs_up;
        check(sdo_oe && !sdo, "R9 busy status", {sdo_oe, sdo}, 2'b10);
        tick(PROG + 20);
        check(sdo_oe && sdo, "R9 ready status", {sdo_oe, sdo}, 2'b11);
        cs_down;
        check(!sdo_oe, "R10 release after poll", sdo_oe, 0);
        do_read(5, 2, "R4 stream word");

        // R9 no status after programming ended
        write_cmd(255, 16'h0f0f);
        tick(PROG + 20);
        cs_up;
        tick(10);
        check(!sdo_oe, "R9 no late status", sdo_oe, 0);
        cs_down;
        do_read(255, 2, "R4 wrap word");

        // R7 R2 erase one word
        cs_up;
        clk_bit(1'b1);
        send_bits(32'b11, 2);
        send_bits(32'd5, 8);
        cs_down;
        tick(PROG + 20);
        put(5, 16'hffff);
        do_read(5, 1, "R7 erase");

        // R12 aborted write
        cs_up;
        clk_bit(1'b1);
        send_bits(32'b01, 2);
        send_bits(32'd7, 8);
        send_bits(32'h15, 5);
        cs_down;
        tick(PROG + 20);
        do_read(7, 1, "R12 abort");

        // R11 command during programming ignored
        write_cmd(9, 16'h1111);
        en_m = 1'b0;
        write_cmd(10, 16'h2222);
        en_m = 1'b1;
        tick(PROG + 20);
        do_read(9, 2, "R11 busy ignore");

        // R5 byte mode: odd byte is high half
        org = 1'b0;
        write_cmd(19, 16'h007e);
        tick(PROG + 20);
        do_read(18, 2, "R5 byte halves");
        do_read(511, 2, "R4 wrap byte");
        org = 1'b1;
        do_read(9, 1, "R5 word view");

        // R7 fill all
        cs_up;
        clk_bit(1'b1);
        send_bits(32'b00, 2);
        send_bits(32'h40, 8);
        send_bits(32'h1234, 16);
        cs_down;
        for (int i = 0; i < 256; i++) mdl[i] = 16'h1234;
        tick(PROG + 20);
        do_read(100, 1, "R7 fill all");

        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        tick(150000);
        bad++;
        total++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule